// File: doc/BRIEF.md
# Channel Self-Test Enable Register and Pattern Source

This block governs built-in self-test for a group of serial channels, some transmit and some receive. A set of active-low enable pins is captured into a holding register under control of a gate input. While the gate is open, the register follows the pins. When the gate closes, the register keeps the last value it captured. A synchronous device reset clears the register, so no channel is in test after reset. The register drives one test-active flag per channel. The receive flags go to a separate checker.

Each transmit channel has its own 9-bit maximal-length LFSR, with polynomial x^9 + x^5 + 1. When test is active on a transmit channel, the channel stops using its user character and control bit. It sends a 10-bit character built from the LFSR state instead, and the sequence repeats every 511 characters. The LFSR sits at a fixed seed while its channel is idle, so every activation starts the same sequence. A remote checker with an identical LFSR can lock onto it. Everything runs on the character clock.

Top module: `chan_selftest_top`

## Requirements
- R1: A clock edge with `rst_n` low clears every test-active flag. The flags read zero from the following cycle.
- R2: While `gate_open` is high at a clock edge, each flag takes the inverse of its `test_en_n` bit. Outputs show the new value one cycle later.
- R3: While `gate_open` is low at a clock edge, every flag keeps its value whatever `test_en_n` does.
- R4: Enable bit i, for i in 0..3, drives transmit channel i (A..D). Bit 4+i drives receive channel i.
- R5: On a transmit channel whose flag is low, `tx_char` equals that channel's user character and `tx_ctl` equals its user control bit, with no added delay.
- R6: On a transmit channel whose flag is high, user character and control inputs have no effect. `tx_ctl` is 0 and `tx_char` comes from the LFSR.
- R7: The LFSR state is S. The character is {parity of S, S[8:0]}, with bit 9 set when S has an odd number of ones. The first character after a flag rises comes from seed 0x1FF, which gives 10'h3FF. Each later cycle the state becomes {S[7:0], S[8]^S[4]}.
- R8: The character sequence of an active channel repeats every 511 cycles and never repeats sooner. The LFSR state is never zero.
- R9: A channel whose test is turned off and then on again restarts from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| gate_open | input | 1 | High: enable register follows pins; low: holds |
| test_en_n | input | 8 | Active-low test enables, [3:0] transmit A..D, [7:4] receive A..D |
| tx_user_char | input | 40 | User characters, 10 bits per transmit channel, channel 0 lowest |
| tx_user_ctl | input | 4 | User control bit per transmit channel |
| tx_test_active | output | 4 | Test-active flag per transmit channel |
| rx_test_active | output | 4 | Test-active flag per receive channel |
| tx_char | output | 40 | Outgoing characters, 10 bits per transmit channel |
| tx_ctl | output | 4 | Outgoing control bit per transmit channel |

## Verification
The assertions assume `rst_n` is held low at the first clock edge, so the enable register and the LFSRs start from known values. They also assume every input is stable around the rising edge. The bench changes all inputs a quarter period after each rising edge and asserts reset from time zero. The hold property relies on `gate_open` being low at the edge where it is checked. The stimulus keeps the gate closed for long stretches, including a full 511-cycle period, and reopens it only between those phases.

// File: rtl/selftest_pkg.sv
// Shared constants and pure functions for the channel self-test block.
// Assumes a 9-bit Fibonacci LFSR, taps x^9 + x^5 + 1, and 10-bit characters.
package selftest_pkg;

    localparam int          PRBS_W    = 9;
    localparam int          CHAR_W    = 10;
    localparam logic [8:0]  PRBS_SEED = 9'h1FF;

    // One LFSR step: shift toward the MSB and feed back bit8 xor bit4.
    function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
        return {s[PRBS_W-2:0], s[8] ^ s[4]};
    endfunction

    // Character from state: parity of the state on top, the state below.
    function automatic logic [CHAR_W-1:0] prbs_char(input logic [PRBS_W-1:0] s);
        return {^s, s};
    endfunction

endpackage

// File: rtl/selftest_enable_reg.sv
// Enable holding register. It stands in for a level-sensitive latch with a
// flop stage that follows the active-low enable pins while the gate is open,
// and holds them while the gate is closed. Reset clears all flags.
// Assumes every input is synchronous to clk.
module selftest_enable_reg #(
    parameter int EN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate_open,
    input  logic [EN_W-1:0] en_n,
    output logic [EN_W-1:0] active
);

    logic [EN_W-1:0] active_q;

    // Capture inverted enables while open, hold while closed, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (gate_open)
            active_q <= ~en_n;
    end

    assign active = active_q;

    AST_FOLLOW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |=> (active == ~$past(en_n)));                     // R2

    AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |=> $stable(active));                             // R3

endmodule

// File: rtl/selftest_pattern_gen.sv
// Per-channel pseudo-random character source. The LFSR sits at the seed
// while its channel is idle and steps once per clock while it is active,
// so each activation starts the same 511-long sequence.
// Assumes 'active' comes from a register clocked by the same clk.
module selftest_pattern_gen
    import selftest_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    output logic [CHAR_W-1:0] pat_char
);

    logic [PRBS_W-1:0] state_q;

    // Seed on reset or while idle, step while active.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            state_q <= PRBS_SEED;
        else
            state_q <= prbs_step(state_q);
    end

    // Map the current state to the outgoing character.
    always_comb pat_char = prbs_char(state_q);

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);                                              // R8

    AST_SEED_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (state_q == PRBS_SEED));                   // R9

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && $past(rst_n)) |->
            (state_q == prbs_step($past(state_q))));                 // R7

endmodule

// File: rtl/selftest_tx_mux.sv
// Output selector for one transmit channel: user traffic when idle, the
// generated pattern with the control bit forced low when in test.
// Purely combinational; assumes all inputs come from the same clock domain.
module selftest_tx_mux
    import selftest_pkg::*;
(
    input  logic              active,
    input  logic [CHAR_W-1:0] user_char,
    input  logic              user_ctl,
    input  logic [CHAR_W-1:0] pat_char,
    output logic [CHAR_W-1:0] out_char,
    output logic              out_ctl
);

    // Pick the pattern over user data when the channel is in test.
    always_comb begin
        if (active) begin
            out_char = pat_char;
            out_ctl  = 1'b0;
        end else begin
            out_char = user_char;
            out_ctl  = user_ctl;
        end
    end

endmodule

// File: rtl/chan_selftest_top.sv
// Channel self-test top: enable register for all channels plus one pattern
// source and output selector per transmit channel. Enable word layout:
// transmit channels in the low bits, receive channels above them.
// Assumes synchronous active-low reset asserted at the first clock edge.
module chan_selftest_top
    import selftest_pkg::*;
#(
    parameter int NUM_TX = 4,
    parameter int NUM_RX = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     gate_open,
    input  logic [NUM_TX+NUM_RX-1:0] test_en_n,
    input  logic [NUM_TX*CHAR_W-1:0] tx_user_char,
    input  logic [NUM_TX-1:0]        tx_user_ctl,
    output logic [NUM_TX-1:0]        tx_test_active,
    output logic [NUM_RX-1:0]        rx_test_active,
    output logic [NUM_TX*CHAR_W-1:0] tx_char,
    output logic [NUM_TX-1:0]        tx_ctl
);

    localparam int EN_W = NUM_TX + NUM_RX;

    logic [EN_W-1:0] active_all;

    selftest_enable_reg #(.EN_W(EN_W)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_open (gate_open),
        .en_n      (test_en_n),
        .active    (active_all)
    );

    // Split the flag word into transmit (low) and receive (high) groups.
    assign tx_test_active = active_all[NUM_TX-1:0];
    assign rx_test_active = active_all[EN_W-1:NUM_TX];

    for (genvar ch = 0; ch < NUM_TX; ch++) begin : g_tx
        logic [CHAR_W-1:0] pat;

        selftest_pattern_gen u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (active_all[ch]),
            .pat_char (pat)
        );

        selftest_tx_mux u_mux (
            .active    (active_all[ch]),
            .user_char (tx_user_char[ch*CHAR_W +: CHAR_W]),
            .user_ctl  (tx_user_ctl[ch]),
            .pat_char  (pat),
            .out_char  (tx_char[ch*CHAR_W +: CHAR_W]),
            .out_ctl   (tx_ctl[ch])
        );
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(!rst_n) |-> (tx_test_active == '0 && rx_test_active == '0)); // R1

endmodule

// File: tb/sim_chan_selftest_top.sv
module sim_chan_selftest_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_open = 1'b1;
    logic [7:0]  test_en_n = 8'hFF;
    logic [39:0] tx_user_char = '0;
    logic [3:0]  tx_user_ctl = '0;
    logic [3:0]  tx_test_active, rx_test_active;
    logic [39:0] tx_char;
    logic [3:0]  tx_ctl;

    int vectors = 0;
    int miss = 0;
    bit done = 1'b0;

    chan_selftest_top u0 (
        .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .test_en_n(test_en_n),
        .tx_user_char(tx_user_char), .tx_user_ctl(tx_user_ctl),
        .tx_test_active(tx_test_active), .rx_test_active(rx_test_active),
        .tx_char(tx_char), .tx_ctl(tx_ctl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // Behavioural reference model: flag word and per-channel LFSR state.
    logic [7:0] m_flag = '0;
    int         m_st [4] = '{511, 511, 511, 511};
    bit         m_prev_rst = 1'b0;
    bit         m_prev_open = 1'b0;
    int         cyc = 0;

    always @(posedge clk) begin
        for (int ch = 0; ch < 4; ch++) begin
            if (!m_flag[ch]) m_st[ch] = 511;              // R9 idle -> seed
            else m_st[ch] = ((m_st[ch] << 1) & 511) |
                            (((m_st[ch] >> 8) ^ (m_st[ch] >> 4)) & 1); // R7
        end
        m_prev_rst  = rst_n;
        m_prev_open = gate_open;
        if (!rst_n) m_flag = '0;
        else if (gate_open) m_flag = ~test_en_n;
        cyc++;
    end

    function automatic logic [9:0] m_char(input int st);
        logic [8:0] s;
        s = st[8:0];
        return {1'(($countones(s)) & 1), s};
    endfunction

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            string lbl;
            lbl = !m_prev_rst ? "R1" : (m_prev_open ? "R2" : "R3");
            chk(lbl, {24'b0, rx_test_active, tx_test_active}, {24'b0, m_flag});
            for (int ch = 0; ch < 4; ch++) begin
                if (m_flag[ch]) begin
                    chk("R6", {22'b0, tx_ctl[ch], tx_char[ch*10 +: 10]},
                        {22'b0, 1'b0, m_char(m_st[ch])});
                end else begin
                    chk("R5", {22'b0, tx_ctl[ch], tx_char[ch*10 +: 10]},
                        {22'b0, tx_user_ctl[ch], tx_user_char[ch*10 +: 10]});
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
        tx_user_char = {$urandom, $urandom};
        tx_user_ctl  = 4'($urandom);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

    initial begin
        logic [9:0] c0;
        int early;
        repeat (3) tick();
        @(negedge clk);
        chk("R1", {28'b0, tx_test_active}, 32'h0);
        tick(); rst_n = 1'b1;
        repeat (4) tick();

        // Enable transmit A only; first pattern character is the seed image.
        test_en_n = 8'hFE;
        @(posedge clk); @(negedge clk);
        chk("R7", {22'b0, tx_char[9:0]}, 32'h3FF);
        repeat (10) tick();

        // Channel mapping: active-low 0x5A -> flags 0xA5.
        test_en_n = 8'h5A;
        @(posedge clk); @(negedge clk);
        chk("R4", {28'b0, tx_test_active}, 32'h5);
        chk("R4", {28'b0, rx_test_active}, 32'hA);
        repeat (5) tick();

        // Close the gate and move the pins: flags must hold.
        gate_open = 1'b0;
        tick(); test_en_n = 8'h00;
        repeat (20) tick();
        test_en_n = 8'hFF;
        @(posedge clk); @(negedge clk);
        chk("R3", {24'b0, rx_test_active, tx_test_active}, 32'hA5);

        // Full period on transmit A with the gate closed.
        tick(); gate_open = 1'b1; test_en_n = 8'hFE;
        tick(); gate_open = 1'b0;
        tick();
        @(negedge clk);
        c0 = tx_char[9:0];
        early = 0;
        for (int i = 1; i < 511; i++) begin
            @(negedge clk);
            if (tx_char[9:0] == c0) early++;
        end
        @(negedge clk);
        chk("R8", 32'(early), 32'd0);
        chk("R8", {22'b0, tx_char[9:0]}, {22'b0, c0});

        // Turn off, then on again: restart from the seed.
        tick(); gate_open = 1'b1; test_en_n = 8'hFF;
        repeat (3) tick();
        test_en_n = 8'hFE;
        @(posedge clk); @(negedge clk);
        chk("R9", {22'b0, tx_char[9:0]}, 32'h3FF);
        repeat (7) tick();

        // Reset while channels are in test.
        test_en_n = 8'h00;
        repeat (4) tick();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1", {24'b0, rx_test_active, tx_test_active}, 32'h0);
        tick(); rst_n = 1'b1;
        repeat (6) tick();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

endmodule